// File: doc/BRIEF.md
# CAN Message Object Interface

This block is the processor-facing side of a CAN controller's message store. It holds a bank of message objects, each with an acceptance mask, an arbitration word (identifier, extended flag, direction, valid flag), a message control word and eight data bytes. The processor never touches an object directly. It loads a set of staging registers, picks which parts of an object to move with a command selection byte, and then writes an object number into the command register. A short transfer engine raises a busy flag and, after a fixed latency, copies the selected parts between the staging registers and the object. The direction bit of the selection byte decides which way the copy goes.

Frames that the protocol engine has received arrive on a one-cycle strobe. The acceptance logic stores each one into the lowest-numbered receive object that is valid, matches and is still empty. Receive objects can be grouped into chains, and a chain is closed by an end-of-buffer flag. When every matching object is full, the frame overwrites the closing object and marks it as lost. Per-object pending, new-data and transmit-request vectors are brought out, together with an interrupt identifier that gives status events priority over object events.

Top module: `can_msgobj_if`

## Requirements
- R1: Register addresses: 2/3 are mask low/high, 4/5 are arbitration low/high, 6 is message control and 7..10 are data words 0..3. Data word w holds byte 2w in bits 7:0 and byte 2w+1 in bits 15:8. The high words carry identifier bits 28:16 in bits 12:0. Arbitration high bit 15 is valid, bit 14 is extended and bit 13 is direction (1 = transmit). Each of these registers reads back what was last written to it or transferred into it. Mask-high bits 15:13 read as zero.
- R2: Writing an object number from 1 to NUM_OBJ to address 0 starts a transfer. Bit 15 of address 0 then reads 1 for exactly XFER_LAT cycles (default 3, never more than 6), and the transferred values are visible when it drops. Bits 7:0 read back the object number. Writing 0 or any number above NUM_OBJ starts nothing.
- R3: A write to address 0 while a transfer is busy is ignored.
- R4: The command selection byte is at address 1. Its bit 7 selects direction (1 = staging to object). Bit 6 selects the mask, bit 5 the arbitration word, bit 4 the control word, bit 1 data bytes 0..3 and bit 0 data bytes 4..7. Parts that are not selected are left unchanged on both sides.
- R5: Selection bit 3 clears the object's interrupt-pending bit in either direction. In a write, selection bit 2 sets the object's transmit-request bit. In a read, selection bit 2 clears the object's new-data bit.
- R6: Control word bits: 15 new-data, 14 message-lost, 13 interrupt-pending, 12 use-mask, 8 transmit-request, 7 end-of-buffer, 3:0 length. Bit n-1 of the new-data, pending and transmit-request output vectors reflects object n.
- R7: A received frame is stored in the lowest-numbered object that is valid, has direction 0, has a matching extended flag and identifier, and has new-data clear. Storing it sets new-data and interrupt-pending and writes the identifier, length and data into the object. A standard identifier arrives already shifted left by 18.
- R8: With use-mask set, only identifier bits whose mask bit is 1 are compared, so an all-zero mask accepts every identifier. With use-mask clear, the whole identifier must be equal. A frame that matches no object changes nothing.
- R9: When no matching object is empty, the frame overwrites the lowest matching object that has end-of-buffer set and sets that object's message-lost bit.
- R10: The interrupt identifier (port and address 11) reads 0x8000 while the status input is high. Otherwise it reads the number of the lowest object with interrupt-pending set, or 0 if no object has it set.
- R11: After reset all objects, staging registers, vectors, the busy flag and the interrupt identifier are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for write and read |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational from regAddr) |
| statusIrq | input | 1 | Pending status event from the protocol engine |
| rxValid | input | 1 | One-cycle strobe for a received frame |
| rxXtd | input | 1 | Received frame uses an extended identifier |
| rxId | input | 29 | Received identifier in arbitration-field form |
| rxDlc | input | 4 | Received length code |
| rxData | input | 64 | Received data, byte 0 in bits 7:0 |
| intPndVec | output | NUM_OBJ | Interrupt-pending bit per object |
| newDatVec | output | NUM_OBJ | New-data bit per object |
| txRqstVec | output | NUM_OBJ | Transmit-request bit per object |
| irqId | output | 16 | Interrupt identifier |

## Verification
A write to a staging register takes effect at the edge that samples it, so the read-back is checked at the next falling edge. A transfer keeps the busy bit high for three falling-edge samples after the command write. The bench counts those samples and reads the staging registers or vectors only after the busy bit has dropped. A received frame is visible on the vectors at the falling edge that follows the edge where rxValid is sampled. The interrupt identifier is combinational from the pending vector and the status input, so it is checked in the same sample as the vector it depends on.

// File: rtl/canmo_pkg.sv
package canmo_pkg;
  // command selection bits
  localparam int SelWr    = 7;
  localparam int SelMask  = 6;
  localparam int SelArb   = 5;
  localparam int SelCtrl  = 4;
  localparam int SelClrIp = 3;
  localparam int SelTxRq  = 2;
  localparam int SelDatLo = 1;
  localparam int SelDatHi = 0;
  // message control bits
  localparam int CtNewDat = 15;
  localparam int CtLost   = 14;
  localparam int CtIpnd   = 13;
  localparam int CtUmask  = 12;
  localparam int CtTxRq   = 8;
  localparam int CtEob    = 7;
  localparam logic [15:0] CtrlKeep = 16'hFF8F;
  // flag triple {valid, extended, direction}
  localparam int FlVal = 2;
  localparam int FlXtd = 1;
  localparam int FlDir = 0;
  localparam int IdW   = 29;
  localparam int DataW = 64;
  // register addresses
  localparam logic [3:0] AdCmdReq = 4'd0;
  localparam logic [3:0] AdCmdSel = 4'd1;
  localparam logic [3:0] AdMaskLo = 4'd2;
  localparam logic [3:0] AdMaskHi = 4'd3;
  localparam logic [3:0] AdArbLo  = 4'd4;
  localparam logic [3:0] AdArbHi  = 4'd5;
  localparam logic [3:0] AdCtrl   = 4'd6;
  localparam logic [3:0] AdData0  = 4'd7;
  localparam logic [3:0] AdIntId  = 4'd11;

  typedef struct packed {
    logic       go;
    logic [7:0] idx;
    logic [7:0] sel;
  } xferStrb_t;
endpackage

// File: rtl/canmo_ctrl.sv
module canmo_ctrl
  import canmo_pkg::*;
#(
  parameter int NUM_OBJ  = 32,
  parameter int XFER_LAT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic        busy,
  output logic [7:0]  cmdSel,
  output logic [7:0]  objNum,
  output xferStrb_t   strb
);
  localparam int CntW = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1;

  logic [CntW-1:0] cnt;
  logic [7:0]      selQ;
  logic            startOk;

  assign startOk = regWrEn && (regAddr == AdCmdReq) && !busy &&
                   (regWrData != 16'd0) && (regWrData <= 16'(NUM_OBJ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      cmdSel <= '0;
      objNum <= '0;
      selQ   <= '0;
    end else begin
      if (regWrEn && regAddr == AdCmdSel) cmdSel <= regWrData[7:0];
      if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end else if (startOk) begin
        busy   <= 1'b1;
        cnt    <= CntW'(XFER_LAT - 1);
        objNum <= regWrData[7:0];
        selQ   <= cmdSel;
      end
    end
  end

  assign strb.go  = busy && (cnt == '0);
  assign strb.idx = objNum - 8'd1;
  assign strb.sel = selQ;
endmodule

// File: rtl/canmo_dpath.sv
module canmo_dpath
  import canmo_pkg::*;
#(
  parameter int NUM_OBJ = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [15:0]        regWrData,
  output logic [15:0]        dpRdData,
  input  xferStrb_t          strb,
  input  logic               statusIrq,
  input  logic               rxValid,
  input  logic               rxXtd,
  input  logic [IdW-1:0]     rxId,
  input  logic [3:0]         rxDlc,
  input  logic [DataW-1:0]   rxData,
  output logic [NUM_OBJ-1:0] intPndVec,
  output logic [NUM_OBJ-1:0] newDatVec,
  output logic [NUM_OBJ-1:0] txRqstVec,
  output logic [15:0]        irqId
);
  localparam int IdxW = $clog2(NUM_OBJ);
  localparam int HalfW = DataW / 2;

  // staging registers
  logic [IdW-1:0]   ifMask, ifId;
  logic [2:0]       ifFlg;
  logic [15:0]      ifCtrl;
  logic [DataW-1:0] ifData;
  // object store
  logic [IdW-1:0]   objMask [NUM_OBJ];
  logic [IdW-1:0]   objId   [NUM_OBJ];
  logic [2:0]       objFlg  [NUM_OBJ];
  logic [15:0]      objCtrl [NUM_OBJ];
  logic [DataW-1:0] objData [NUM_OBJ];

  logic [NUM_OBJ-1:0] cand;
  logic               hitFree, hitEob, rxTake;
  logic [IdxW-1:0]    freeIdx, eobIdx, rxIdx;
  logic [1:0]         wordIdx;
  logic               dataAddr;
  logic [IdW-1:0]     srcMask, srcId;
  logic [2:0]         srcFlg;
  logic [15:0]        srcCtrl;
  logic [DataW-1:0]   srcData;

  for (genvar k = 0; k < NUM_OBJ; k++) begin : g_obj
    assign cand[k] = objFlg[k][FlVal] && !objFlg[k][FlDir] &&
                     (objFlg[k][FlXtd] == rxXtd) &&
                     (objCtrl[k][CtUmask] ? (((objId[k] ^ rxId) & objMask[k]) == '0)
                                          : (objId[k] == rxId));
    assign intPndVec[k] = objCtrl[k][CtIpnd];
    assign newDatVec[k] = objCtrl[k][CtNewDat];
    assign txRqstVec[k] = objCtrl[k][CtTxRq];
  end

  // lowest free match, and lowest full chain end as overflow target
  always_comb begin
    hitFree = 1'b0; hitEob = 1'b0; freeIdx = '0; eobIdx = '0;
    for (int k = NUM_OBJ - 1; k >= 0; k--) begin
      if (cand[k] && !objCtrl[k][CtNewDat]) begin hitFree = 1'b1; freeIdx = IdxW'(k); end
      if (cand[k] && objCtrl[k][CtEob])     begin hitEob  = 1'b1; eobIdx  = IdxW'(k); end
    end
  end
  assign rxTake = rxValid && (hitFree || hitEob);
  assign rxIdx  = hitFree ? freeIdx : eobIdx;

  // object selected by the transfer engine
  always_comb begin
    srcMask = '0; srcId = '0; srcFlg = '0; srcCtrl = '0; srcData = '0;
    for (int k = 0; k < NUM_OBJ; k++) begin
      if (strb.idx == 8'(k)) begin
        srcMask = objMask[k]; srcId = objId[k]; srcFlg = objFlg[k];
        srcCtrl = objCtrl[k]; srcData = objData[k];
      end
    end
  end

  assign wordIdx  = 2'(regAddr - AdData0);
  assign dataAddr = (regAddr >= AdData0) && (regAddr < AdIntId);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ifMask <= '0; ifId <= '0; ifFlg <= '0; ifCtrl <= '0; ifData <= '0;
      for (int k = 0; k < NUM_OBJ; k++) begin
        objMask[k] <= '0; objId[k] <= '0; objFlg[k] <= '0;
        objCtrl[k] <= '0; objData[k] <= '0;
      end
    end else begin
      if (regWrEn) begin
        case (regAddr)
          AdMaskLo: ifMask[15:0]      <= regWrData;
          AdMaskHi: ifMask[IdW-1:16]  <= regWrData[12:0];
          AdArbLo:  ifId[15:0]        <= regWrData;
          AdArbHi:  {ifFlg, ifId[IdW-1:16]} <= regWrData;
          AdCtrl:   ifCtrl            <= regWrData;
          default: if (dataAddr) ifData[16*wordIdx +: 16] <= regWrData;
        endcase
      end
      // read-direction transfer into staging registers
      if (strb.go && !strb.sel[SelWr]) begin
        if (strb.sel[SelMask])  ifMask <= srcMask;
        if (strb.sel[SelArb])   begin ifId <= srcId; ifFlg <= srcFlg; end
        if (strb.sel[SelCtrl])  ifCtrl <= srcCtrl;
        if (strb.sel[SelDatLo]) ifData[HalfW-1:0]     <= srcData[HalfW-1:0];
        if (strb.sel[SelDatHi]) ifData[DataW-1:HalfW] <= srcData[DataW-1:HalfW];
      end
      for (int k = 0; k < NUM_OBJ; k++) begin
        if (rxTake && rxIdx == IdxW'(k)) begin
          objId[k]             <= rxId;
          objData[k]           <= rxData;
          objCtrl[k][3:0]      <= rxDlc;
          objCtrl[k][CtNewDat] <= 1'b1;
          objCtrl[k][CtIpnd]   <= 1'b1;
          if (!hitFree) objCtrl[k][CtLost] <= 1'b1;
        end
        if (strb.go && strb.idx == 8'(k)) begin
          if (strb.sel[SelWr]) begin
            if (strb.sel[SelMask])  objMask[k] <= ifMask;
            if (strb.sel[SelArb])   begin objId[k] <= ifId; objFlg[k] <= ifFlg; end
            if (strb.sel[SelCtrl])  objCtrl[k] <= ifCtrl & CtrlKeep;
            if (strb.sel[SelDatLo]) objData[k][HalfW-1:0]     <= ifData[HalfW-1:0];
            if (strb.sel[SelDatHi]) objData[k][DataW-1:HalfW] <= ifData[DataW-1:HalfW];
            if (strb.sel[SelTxRq])  objCtrl[k][CtTxRq] <= 1'b1;
          end else if (strb.sel[SelTxRq]) begin
            objCtrl[k][CtNewDat] <= 1'b0;
          end
          if (strb.sel[SelClrIp]) objCtrl[k][CtIpnd] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    irqId = 16'd0;
    for (int k = NUM_OBJ - 1; k >= 0; k--)
      if (intPndVec[k]) irqId = 16'(k + 1);
    if (statusIrq) irqId = 16'h8000;
  end

  always_comb begin
    case (regAddr)
      AdMaskLo: dpRdData = ifMask[15:0];
      AdMaskHi: dpRdData = {3'b000, ifMask[IdW-1:16]};
      AdArbLo:  dpRdData = ifId[15:0];
      AdArbHi:  dpRdData = {ifFlg, ifId[IdW-1:16]};
      AdCtrl:   dpRdData = ifCtrl;
      AdIntId:  dpRdData = irqId;
      default:  dpRdData = dataAddr ? ifData[16*wordIdx +: 16] : 16'd0;
    endcase
  end
endmodule

// File: rtl/can_msgobj_if.sv
module can_msgobj_if
  import canmo_pkg::*;
#(
  parameter int NUM_OBJ  = 32,
  parameter int XFER_LAT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [15:0]        regWrData,
  output logic [15:0]        regRdData,
  input  logic               statusIrq,
  input  logic               rxValid,
  input  logic               rxXtd,
  input  logic [28:0]        rxId,
  input  logic [3:0]         rxDlc,
  input  logic [63:0]        rxData,
  output logic [NUM_OBJ-1:0] intPndVec,
  output logic [NUM_OBJ-1:0] newDatVec,
  output logic [NUM_OBJ-1:0] txRqstVec,
  output logic [15:0]        irqId
);
  logic        busy;
  logic [7:0]  cmdSel, objNum;
  logic [15:0] dpRdData;
  xferStrb_t   strb;

  canmo_ctrl #(.NUM_OBJ(NUM_OBJ), .XFER_LAT(XFER_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .busy(busy), .cmdSel(cmdSel), .objNum(objNum),
    .strb(strb)
  );

  canmo_dpath #(.NUM_OBJ(NUM_OBJ)) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .dpRdData(dpRdData), .strb(strb),
    .statusIrq(statusIrq), .rxValid(rxValid), .rxXtd(rxXtd), .rxId(rxId),
    .rxDlc(rxDlc), .rxData(rxData), .intPndVec(intPndVec),
    .newDatVec(newDatVec), .txRqstVec(txRqstVec), .irqId(irqId)
  );

  always_comb begin
    case (regAddr)
      AdCmdReq: regRdData = {busy, 7'd0, objNum};
      AdCmdSel: regRdData = {8'd0, cmdSel};
      default:  regRdData = dpRdData;
    endcase
  end
endmodule

// File: rtl/can_msgobj_if_chk.sv
module can_msgobj_if_chk #(
  parameter int NUM_OBJ = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [3:0]         regAddr,
  input logic               statusIrq,
  input logic               rxValid,
  input logic               busy,
  input logic               xferGo,
  input logic [NUM_OBJ-1:0] intPndVec,
  input logic [NUM_OBJ-1:0] newDatVec,
  input logic [NUM_OBJ-1:0] txRqstVec,
  input logic [15:0]        irqId
);
  logic [3:0] busyRun;
  logic       idOk;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 4'd1;
    else           busyRun <= '0;
  end

  always_comb begin
    idOk = 1'b0;
    for (int k = 0; k < NUM_OBJ; k++)
      if (irqId == 16'(k + 1))
        idOk = intPndVec[k] && ((intPndVec & ((NUM_OBJ'(1) << k) - 1'b1)) == '0);
  end

  a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyRun < 4'd6);
  a_r2_busy_started: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn && regAddr == 4'd0));
  a_r7_newdat_source: assert property (@(posedge clk) disable iff (!rstN)
    ((newDatVec & ~$past(newDatVec)) != '0) |-> ($past(rxValid) || $past(xferGo)));
  a_r5_txrq_source: assert property (@(posedge clk) disable iff (!rstN)
    ((txRqstVec & ~$past(txRqstVec)) != '0) |-> $past(xferGo));
  a_r10_status_first: assert property (@(posedge clk) disable iff (!rstN)
    statusIrq |-> irqId == 16'h8000);
  a_r10_lowest_pending: assert property (@(posedge clk) disable iff (!rstN)
    (!statusIrq && irqId != 16'd0) |-> idOk);
  a_r10_none_pending: assert property (@(posedge clk) disable iff (!rstN)
    (!statusIrq && intPndVec == '0) |-> irqId == 16'd0);
endmodule

bind can_msgobj_if can_msgobj_if_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .statusIrq(statusIrq), .rxValid(rxValid), .busy(busy), .xferGo(strb.go),
  .intPndVec(intPndVec), .newDatVec(newDatVec), .txRqstVec(txRqstVec),
  .irqId(irqId)
);

// File: tb/can_msgobj_if_tb.sv
module can_msgobj_if_tb;
  localparam int LAT = 3;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic statusIrq = 1'b0, rxValid = 1'b0, rxXtd = 1'b0;
  logic [28:0] rxId = '0;
  logic [3:0] rxDlc = '0;
  logic [63:0] rxData = '0;
  logic [31:0] intPndVec, newDatVec, txRqstVec;
  logic [15:0] irqId;
  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  can_msgobj_if u_dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    regAddr = a; #0.5; d = regRdData;
  endtask

  task automatic waitIdle(output int cycles);
    logic [15:0] v;
    cycles = 0;
    rd(4'd0, v);
    while (v[15] && cycles < 20) begin
      cycles++; @(negedge clk); rd(4'd0, v);
    end
  endtask

  task automatic xfer(input int n, input logic [7:0] sel);
    int c;
    wr(4'd1, {8'd0, sel});
    wr(4'd0, 16'(n));
    waitIdle(c);
    check("R2 busy length", 64'(c), 64'(LAT));
  endtask

  task automatic setIf(input logic [28:0] m, input logic [2:0] f, input logic [28:0] id,
                       input logic [15:0] ct, input logic [63:0] d);
    wr(4'd2, m[15:0]); wr(4'd3, {3'd0, m[28:16]});
    wr(4'd4, id[15:0]); wr(4'd5, {f, id[28:16]});
    wr(4'd6, ct);
    for (int w = 0; w < 4; w++) wr(4'(7 + w), d[16*w +: 16]);
  endtask

  task automatic rxFrame(input logic x, input logic [28:0] id, input logic [63:0] d);
    @(negedge clk); rxValid = 1'b1; rxXtd = x; rxId = id; rxDlc = 4'd8; rxData = d;
    @(negedge clk); rxValid = 1'b0;
    #0.5;
  endtask

  function automatic logic [63:0] objData(input int n);
    logic [63:0] r;
    for (int w = 0; w < 4; w++) r[16*w +: 16] = 16'(n * 16 + w);
    return r;
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R11 reset state
    rd(4'd0, v);  check("R11 cmd reg", v, 0);
    rd(4'd11, v); check("R11 int id", v, 0);
    check("R11 vectors", {newDatVec, intPndVec}, 0);
    check("R11 txrq", txRqstVec, 0);
    rd(4'd7, v);  check("R11 data0", v, 0);

    // R1 staging register map
    wr(4'd3, 16'hFFFF); rd(4'd3, v); check("R1 mask high", v, 16'h1FFF);
    wr(4'd5, 16'hA123); rd(4'd5, v); check("R1 arb high", v, 16'hA123);
    wr(4'd9, 16'h1234); rd(4'd9, v); check("R1 data word2", v, 16'h1234);
    wr(4'd6, 16'h5A5A); rd(4'd6, v); check("R1 ctrl", v, 16'h5A5A);
    wr(4'd1, 16'h00B7); rd(4'd1, v); check("R4 select reg", v, 16'h00B7);

    // R4/R6 sweep: transmit objects, transmit request on odd objects
    for (int n = 1; n <= 32; n++) begin
      setIf(29'd0, 3'b101, 29'(n * 7), 16'(n % 16), objData(n));
      xfer(n, (n % 2 == 1) ? 8'hF7 : 8'hF3);
    end
    check("R6 txrq vector", txRqstVec, 32'h5555_5555);
    check("R6 pending vector", intPndVec, 0);
    for (int n = 1; n <= 32; n++) begin
      xfer(n, 8'h73);
      rd(4'd4, v);  check("R4 arb low readback", v, 16'(n * 7));
      rd(4'd5, v);  check("R4 arb high readback", v, 16'hA000);
      rd(4'd6, v);  check("R6 ctrl readback", v, 16'(n % 16) | ((n % 2 == 1) ? 16'h0100 : 16'h0));
      rd(4'd10, v); check("R4 data word3", v, 16'(n * 16 + 3));
      rd(4'd0, v);  check("R2 object number", v, 16'(n));
    end

    // R4 partial read selection sweep on object 5
    for (int s = 0; s < 16; s++) begin
      wr(4'd4, 16'hBEEF); wr(4'd6, 16'hC0DE); wr(4'd7, 16'hF00D); wr(4'd9, 16'hFACE);
      xfer(5, {2'b00, s[3], s[2], 2'b00, s[1], s[0]});
      rd(4'd4, v); check("R4 sel arb", v, s[3] ? 16'd35 : 16'hBEEF);
      rd(4'd6, v); check("R4 sel ctrl", v, s[2] ? 16'h0105 : 16'hC0DE);
      rd(4'd7, v); check("R4 sel data lo", v, s[1] ? 16'd80 : 16'hF00D);
      rd(4'd9, v); check("R4 sel data hi", v, s[0] ? 16'd82 : 16'hFACE);
    end

    // R4 partial write: data bytes 0..3 only into object 6
    setIf(29'h1FFF_FFFF, 3'b111, 29'h0AAA_AAAA, 16'hFFFF, {4{16'hAAAA}});
    xfer(6, 8'h82);
    xfer(6, 8'h23);
    rd(4'd7, v);  check("R4 written low word0", v, 16'hAAAA);
    rd(4'd8, v);  check("R4 written low word1", v, 16'hAAAA);
    rd(4'd9, v);  check("R4 kept high word2", v, 16'd98);
    rd(4'd4, v);  check("R4 kept arb", v, 16'd42);
    check("R4 kept txrq", txRqstVec, 32'h5555_5555);

    // R3 command ignored while busy
    wr(4'd4, 16'h0000);
    wr(4'd1, 16'h0020);
    wr(4'd0, 16'd20);
    wr(4'd0, 16'd21);
    waitIdle(c);
    rd(4'd4, v); check("R3 busy write ignored arb", v, 16'd140);
    rd(4'd0, v); check("R3 busy write ignored num", v, 16'd20);

    // R2 out-of-range object numbers start nothing
    wr(4'd0, 16'd0);  rd(4'd0, v); check("R2 zero no start", v[15], 0);
    wr(4'd0, 16'd33); rd(4'd0, v); check("R2 over range no start", v, 16'd20);

    // R5/R10 clear pending on write
    setIf(29'd0, 3'b101, 29'd0, 16'h2000, 64'd0);
    xfer(7, 8'h90);
    check("R10 lowest pending", irqId, 16'd7);
    xfer(7, 8'h88);
    check("R5 clear pending write", intPndVec, 0);
    rd(4'd11, v); check("R10 none pending", v, 0);

    // invalidate everything
    setIf(29'd0, 3'b000, 29'd0, 16'h0000, 64'd0);
    for (int n = 1; n <= 32; n++) xfer(n, 8'hB0);
    check("R6 txrq cleared", txRqstVec, 0);

    // receive configuration: chain 1..4 extended any-id, 10 exact std, 12 masked std
    for (int n = 1; n <= 4; n++) begin
      setIf(29'd0, 3'b110, 29'd0, (n == 4) ? 16'h1080 : 16'h1000, 64'd0);
      xfer(n, 8'hF0);
    end
    setIf(29'd0, 3'b100, 29'(11'h123) << 18, 16'h0080, 64'd0);
    xfer(10, 8'hF0);
    setIf(29'(11'h7F0) << 18, 3'b100, 29'(11'h550) << 18, 16'h1080, 64'd0);
    xfer(12, 8'hF0);

    rxFrame(1'b0, 29'(11'h123) << 18, 64'h1111);
    check("R7 exact match object 10", newDatVec, 32'h0000_0200);
    check("R10 id object 10", irqId, 16'd10);
    rxFrame(1'b0, 29'(11'h55A) << 18, 64'h2222);
    check("R8 masked match object 12", newDatVec, 32'h0000_0A00);
    rxFrame(1'b0, 29'(11'h124) << 18, 64'h3333);
    check("R8 no match unchanged", newDatVec, 32'h0000_0A00);
    for (int k = 1; k <= 5; k++) begin
      rxFrame(1'b1, 29'h0ABC_DE00 + 29'(k), {8{8'(k)}});
      check("R7 chain fill", newDatVec[3:0], (k >= 4) ? 4'hF : 4'((1 << k) - 1));
    end
    check("R10 lowest after fill", irqId, 16'd1);
    xfer(4, 8'h13);
    rd(4'd6, v); check("R9 lost flag on chain end", v, 16'hF088);
    rd(4'd7, v); check("R9 overwrite data", v, 16'h0505);

    // R5 read with clear pending and new-data clear
    xfer(1, 8'h7F);
    check("R5 read clears newdat", newDatVec[0], 0);
    check("R5 read clears pending", intPndVec[0], 0);
    check("R10 next lowest", irqId, 16'd2);
    rd(4'd4, v); check("R7 stored id", v, 16'hDE01);
    rd(4'd7, v); check("R7 stored data", v, 16'h0101);
    rxFrame(1'b1, 29'h0ABC_DE06, {8{8'h06}});
    check("R7 lowest free refill", newDatVec[3:0], 4'hF);
    check("R10 refilled lowest", irqId, 16'd1);

    // R10 status priority
    @(negedge clk); statusIrq = 1'b1; #0.5;
    rd(4'd11, v); check("R10 status priority", v, 16'h8000);
    @(negedge clk); statusIrq = 1'b0; #0.5;
    check("R10 status released", irqId, 16'd1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule